// File: doc/BRIEF.md
# Switch ASIC and Host Reset Sequencer

This block is the reset and power-state controller of a network switch board. It holds the host CPU, the switching ASIC and the optical ports in a known state from chassis power-up onward. Each domain is then released on its own schedule. The host CPU stays powered off until the board management controller asks for it. The ASIC chip comes out of reset once the supply has been stable for a fixed time. The optical ports stay in reset and low-power until software releases them port by port.

A host reboot appears on the platform-reset input. It reaches only the ASIC PCIe reset, so in-band traffic through the ASIC keeps flowing across host reboots. A chip-level ASIC reset happens only when software writes the recovery register. That reset is a timed pulse that ends by itself. Host power commands never touch the optical ports. Only a full chassis reset command returns every domain to its power-up state.

Top module: `swrst_seq`

## Requirements
- R1: After `rst`, the outputs take these values: `host_pwr_en`=0, `host_rst`=1, `asic_chip_rst`=1, `asic_pcie_rst`=1, and every bit of `optics_rst` and `optics_lpmode` is 1.
- R2: `asic_chip_rst` deasserts after `power_good` has been sampled high on CHIP_DLY (default 1024) consecutive rising edges. A low sample restarts the count. Once released, it ignores later changes of `power_good`.
- R3: Command code 0 (host on) sent while the host is off sets `host_pwr_en` on the next edge and releases `host_rst` HOST_DLY (default 64) edges after the command edge. Code 1 (host off) clears `host_pwr_en` and asserts `host_rst`. `host_rst` is 1 whenever `host_pwr_en` is 0.
- R4: `asic_pcie_rst` follows a low level on `host_plat_rst_n` after a two-flop synchronizer (2 edges) and releases 2 edges after it returns high. `asic_chip_rst` is not affected.
- R5: A write to address 1 with data bit 0 set asserts `asic_chip_rst` and `asic_pcie_rst` for exactly RECOV_CYC (default 256) cycles, then both release by themselves. The same write with bit 0 clear has no effect.
- R6: Host commands 0, 1 and 2 never change `optics_rst` or `optics_lpmode`.
- R7: Command code 3 (chassis reset) returns every output and register to the R1 state on the next edge. This includes the optics registers and the ASIC release count.
- R8: Data bit k of a write to address 2 drives `optics_rst[k+1]`, and data bit k of a write to address 3 drives `optics_lpmode[k+1]`. Ports are numbered from 1. Reads of addresses 2 and 3 return the stored bits in positions 0 and up.
- R9: Reading address 0 returns the version: major in bits 15:8 (default 1), minor in bits 7:0 (default 3), so 16'h0103. Writes to address 0 are ignored.
- R10: Command code 2 (host reset) re-asserts `host_rst` for HOST_DLY cycles while the host is powered. The same command while the host is off has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chassis power-on reset |
| power_good | input | 1 | Board supplies stable |
| host_plat_rst_n | input | 1 | Host platform reset, active low, asynchronous |
| pwr_cmd_valid | input | 1 | Management controller command strobe |
| pwr_cmd | input | 2 | 0 host on, 1 host off, 2 host reset, 3 chassis reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (read and write) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| host_pwr_en | output | 1 | Host CPU power enable |
| host_rst | output | 1 | Host CPU reset, active high |
| asic_chip_rst | output | 1 | ASIC chip-level reset, active high |
| asic_pcie_rst | output | 1 | ASIC PCIe reset, active high |
| optics_rst | output | NUM_PORTS | Per-port optics reset, index = port number |
| optics_lpmode | output | NUM_PORTS | Per-port optics low-power, index = port number |

## Verification
Several properties are checked on every cycle. The ASIC chip reset rises only after a recovery write or a chassis command. The optics lines change only after their own register writes or a chassis command. The host is always in reset while unpowered. The chip reset always implies the PCIe reset, a chassis command always restores the power-up state, and the version read is constant. Some behaviour can be shown only by the bench's timed scenarios: the exact 1024-edge release with its restart on a supply glitch, the 64-cycle host release, the two-edge synchronizer latency, the exact 256-cycle recovery pulse, and the 1-based port mapping. The bench follows each of these with a behavioural model on every clock.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Management controller command codes
    typedef enum logic [1:0] {
        CMD_HOST_ON    = 2'd0,
        CMD_HOST_OFF   = 2'd1,
        CMD_HOST_CYCLE = 2'd2,
        CMD_CHASSIS    = 2'd3
    } pwr_cmd_e;

    // Host power state
    typedef enum logic [1:0] {
        HOST_OFF  = 2'd0,
        HOST_WAIT = 2'd1,
        HOST_RUN  = 2'd2
    } host_state_e;

    // Register map
    typedef enum logic [1:0] {
        ADDR_VERSION = 2'd0,
        ADDR_RECOVER = 2'd1,
        ADDR_OPT_RST = 2'd2,
        ADDR_OPT_LP  = 2'd3
    } reg_addr_e;

    localparam int REG_AW = 2;

    function automatic logic [15:0] pack_version(input logic [7:0] major,
                                                 input logic [7:0] minor);
        return {major, minor};
    endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= (chain_q << 1) | STAGES'(d);
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_host_ctrl.sv
module rsq_host_ctrl
    import rsq_pkg::*;
#(
    parameter int HOST_DLY = 64
) (
    input  logic     clk,
    input  logic     clr,
    input  logic     cmd_valid,
    input  pwr_cmd_e cmd,
    output logic     host_pwr_en,
    output logic     host_rst
);
    localparam int CW = (HOST_DLY > 1) ? $clog2(HOST_DLY) : 1;

    host_state_e    state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           want_on, want_off, want_cycle;

    assign want_on    = cmd_valid && (cmd == CMD_HOST_ON);
    assign want_off   = cmd_valid && (cmd == CMD_HOST_OFF);
    assign want_cycle = cmd_valid && (cmd == CMD_HOST_CYCLE);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HOST_OFF: begin
                if (want_on) begin
                    state_d = HOST_WAIT;
                    cnt_d   = '0;
                end
            end
            HOST_WAIT: begin
                if (want_off) begin
                    state_d = HOST_OFF;
                end else if (want_cycle) begin
                    cnt_d = '0;
                end else if (cnt_q == CW'(HOST_DLY - 1)) begin
                    state_d = HOST_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            HOST_RUN: begin
                if (want_off) begin
                    state_d = HOST_OFF;
                end else if (want_cycle) begin
                    state_d = HOST_WAIT;
                    cnt_d   = '0;
                end
            end
            default: state_d = HOST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= HOST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign host_pwr_en = (state_q != HOST_OFF);
    assign host_rst    = (state_q != HOST_RUN);
endmodule

// File: rtl/rsq_asic_ctrl.sv
module rsq_asic_ctrl #(
    parameter int CHIP_DLY  = 1024,
    parameter int RECOV_CYC = 256
) (
    input  logic clk,
    input  logic clr,
    input  logic power_good,
    input  logic plat_rst_active,
    input  logic recov_start,
    output logic chip_rst,
    output logic pcie_rst
);
    localparam int DC = (CHIP_DLY > 1) ? $clog2(CHIP_DLY) : 1;
    localparam int RW = $clog2(RECOV_CYC + 1);

    logic          released_q;
    logic [DC-1:0] pg_cnt_q;
    logic [RW-1:0] rec_cnt_q;

    // Power-up release: counts consecutive power-good samples
    always_ff @(posedge clk) begin
        if (clr) begin
            released_q <= 1'b0;
            pg_cnt_q   <= '0;
        end else if (!released_q) begin
            if (power_good) begin
                if (pg_cnt_q == DC'(CHIP_DLY - 1)) released_q <= 1'b1;
                else                                pg_cnt_q   <= pg_cnt_q + 1'b1;
            end else begin
                pg_cnt_q <= '0;
            end
        end
    end

    // Recovery pulse: fixed-length window, restarts on a new request
    always_ff @(posedge clk) begin
        if (clr)                   rec_cnt_q <= '0;
        else if (recov_start)      rec_cnt_q <= RW'(RECOV_CYC);
        else if (rec_cnt_q != '0)  rec_cnt_q <= rec_cnt_q - 1'b1;
    end

    assign chip_rst = !released_q || (rec_cnt_q != '0);
    assign pcie_rst = chip_rst || plat_rst_active;
endmodule

// File: rtl/rsq_regs.sv
module rsq_regs
    import rsq_pkg::*;
#(
    parameter int         NUM_PORTS = 8,
    parameter int         DW        = 16,
    parameter logic [7:0] VER_MAJOR = 8'd1,
    parameter logic [7:0] VER_MINOR = 8'd3
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [NUM_PORTS-1:0] opt_rst_vec,
    output logic [NUM_PORTS-1:0] opt_lp_vec,
    output logic                 recov_start
);
    logic [NUM_PORTS-1:0] rst_bits_q, lp_bits_q;
    reg_addr_e            sel;

    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (clr) begin
            rst_bits_q <= '1;
            lp_bits_q  <= '1;
        end else if (wr_en) begin
            if (sel == ADDR_OPT_RST) rst_bits_q <= wdata[NUM_PORTS-1:0];
            if (sel == ADDR_OPT_LP)  lp_bits_q  <= wdata[NUM_PORTS-1:0];
        end
    end

    assign recov_start = wr_en && (sel == ADDR_RECOVER) && wdata[0];

    always_comb begin
        rdata = '0;
        unique case (sel)
            ADDR_VERSION: rdata = DW'(pack_version(VER_MAJOR, VER_MINOR));
            ADDR_RECOVER: rdata = '0;
            ADDR_OPT_RST: rdata[NUM_PORTS-1:0] = rst_bits_q;
            ADDR_OPT_LP:  rdata[NUM_PORTS-1:0] = lp_bits_q;
            default:      rdata = '0;
        endcase
    end

    generate
        if (NUM_PORTS < DW) begin : g_spare
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata[DW-1:NUM_PORTS];
        end
    endgenerate

    assign opt_rst_vec = rst_bits_q;
    assign opt_lp_vec  = lp_bits_q;
endmodule

// File: rtl/swrst_seq.sv
module swrst_seq
    import rsq_pkg::*;
#(
    parameter int         NUM_PORTS   = 8,
    parameter int         DW          = 16,
    parameter int         CHIP_DLY    = 1024,
    parameter int         RECOV_CYC   = 256,
    parameter int         HOST_DLY    = 64,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] VER_MAJOR   = 8'd1,
    parameter logic [7:0] VER_MINOR   = 8'd3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 power_good,
    input  logic                 host_plat_rst_n,
    input  logic                 pwr_cmd_valid,
    input  logic [1:0]           pwr_cmd,
    input  logic                 reg_wr_en,
    input  logic [1:0]           reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 host_pwr_en,
    output logic                 host_rst,
    output logic                 asic_chip_rst,
    output logic                 asic_pcie_rst,
    output logic [NUM_PORTS:1]   optics_rst,
    output logic [NUM_PORTS:1]   optics_lpmode
);
    pwr_cmd_e             cmd;
    logic                 chassis_req, clr;
    logic                 plat_n_sync, recov_start;
    logic [NUM_PORTS-1:0] opt_rst_vec, opt_lp_vec;

    assign cmd         = pwr_cmd_e'(pwr_cmd);
    assign chassis_req = pwr_cmd_valid && (cmd == CMD_CHASSIS);
    assign clr         = rst || chassis_req;

    // Platform reset crosses in from the host; synchronizer resets to "in reset"
    rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_plat_sync (
        .clk (clk),
        .rst (rst),
        .d   (host_plat_rst_n),
        .q   (plat_n_sync)
    );

    rsq_host_ctrl #(.HOST_DLY(HOST_DLY)) u_host (
        .clk         (clk),
        .clr         (clr),
        .cmd_valid   (pwr_cmd_valid),
        .cmd         (cmd),
        .host_pwr_en (host_pwr_en),
        .host_rst    (host_rst)
    );

    rsq_asic_ctrl #(.CHIP_DLY(CHIP_DLY), .RECOV_CYC(RECOV_CYC)) u_asic (
        .clk             (clk),
        .clr             (clr),
        .power_good      (power_good),
        .plat_rst_active (!plat_n_sync),
        .recov_start     (recov_start),
        .chip_rst        (asic_chip_rst),
        .pcie_rst        (asic_pcie_rst)
    );

    rsq_regs #(
        .NUM_PORTS (NUM_PORTS),
        .DW        (DW),
        .VER_MAJOR (VER_MAJOR),
        .VER_MINOR (VER_MINOR)
    ) u_regs (
        .clk         (clk),
        .clr         (clr),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .opt_rst_vec (opt_rst_vec),
        .opt_lp_vec  (opt_lp_vec),
        .recov_start (recov_start)
    );

    // Register bit k belongs to port k+1
    assign optics_rst    = opt_rst_vec;
    assign optics_lpmode = opt_lp_vec;
endmodule

// File: rtl/swrst_seq_chk.sv
module swrst_seq_chk #(
    parameter int         NUM_PORTS = 8,
    parameter int         DW        = 16,
    parameter logic [7:0] VER_MAJOR = 8'd1,
    parameter logic [7:0] VER_MINOR = 8'd3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 host_plat_rst_n,
    input logic                 pwr_cmd_valid,
    input logic [1:0]           pwr_cmd,
    input logic                 reg_wr_en,
    input logic [1:0]           reg_addr,
    input logic [DW-1:0]        reg_wdata,
    input logic [DW-1:0]        reg_rdata,
    input logic                 host_pwr_en,
    input logic                 host_rst,
    input logic                 asic_chip_rst,
    input logic                 asic_pcie_rst,
    input logic [NUM_PORTS:1]   optics_rst,
    input logic [NUM_PORTS:1]   optics_lpmode
);
    logic chassis_w, recov_w, orst_w, olp_w;

    assign chassis_w = pwr_cmd_valid && (pwr_cmd == 2'd3);
    assign recov_w   = reg_wr_en && (reg_addr == 2'd1) && reg_wdata[0];
    assign orst_w    = reg_wr_en && (reg_addr == 2'd2);
    assign olp_w     = reg_wr_en && (reg_addr == 2'd3);

    // R5
    chip_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(asic_chip_rst) |-> ($past(recov_w) || $past(chassis_w)));

    // R4
    pcie_only_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(asic_pcie_rst) && !$past(recov_w) && !$past(chassis_w)) |-> !asic_chip_rst);

    // R5
    chip_pcie_chk: assert property (@(posedge clk) disable iff (rst)
        asic_chip_rst |-> asic_pcie_rst);

    // R6
    opt_rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(optics_rst) |-> ($past(orst_w) || $past(chassis_w)));

    // R6
    opt_lp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(optics_lpmode) |-> ($past(olp_w) || $past(chassis_w)));

    // R3
    host_off_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !host_pwr_en |-> host_rst);

    // R7
    chassis_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(chassis_w) |-> ((&optics_rst) && (&optics_lpmode) && !host_pwr_en
                              && asic_chip_rst));

    // R9
    version_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> (reg_rdata[15:0] == {VER_MAJOR, VER_MINOR}));

    logic unused_plat;
    assign unused_plat = host_plat_rst_n;
endmodule

bind swrst_seq swrst_seq_chk #(
    .NUM_PORTS (NUM_PORTS),
    .DW        (DW),
    .VER_MAJOR (VER_MAJOR),
    .VER_MINOR (VER_MINOR)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .host_plat_rst_n (host_plat_rst_n),
    .pwr_cmd_valid   (pwr_cmd_valid),
    .pwr_cmd         (pwr_cmd),
    .reg_wr_en       (reg_wr_en),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .host_pwr_en     (host_pwr_en),
    .host_rst        (host_rst),
    .asic_chip_rst   (asic_chip_rst),
    .asic_pcie_rst   (asic_pcie_rst),
    .optics_rst      (optics_rst),
    .optics_lpmode   (optics_lpmode)
);

// File: tb/swrst_seq_tb.sv
`timescale 1ns/1ps
module swrst_seq_tb;
    localparam int NP       = 8;
    localparam int DW       = 16;
    localparam int CHIP_DLY = 1024;
    localparam int RECOV    = 256;
    localparam int HD       = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pg = 1'b0;
    logic          plat_n = 1'b1;
    logic          cmd_v = 1'b0;
    logic [1:0]    cmd = 2'd0;
    logic          wr = 1'b0;
    logic [1:0]    addr = 2'd1;
    logic [DW-1:0] wdata = '0;

    logic [DW-1:0] rdata;
    logic          host_pwr_en, host_rst, chip_rst, pcie_rst;
    logic [NP:1]   o_rst, o_lp;

    swrst_seq #(.NUM_PORTS(NP), .DW(DW), .CHIP_DLY(CHIP_DLY),
                .RECOV_CYC(RECOV), .HOST_DLY(HD)) u_dut (
        .clk(clk), .rst(rst), .power_good(pg), .host_plat_rst_n(plat_n),
        .pwr_cmd_valid(cmd_v), .pwr_cmd(cmd), .reg_wr_en(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .host_pwr_en(host_pwr_en),
        .host_rst(host_rst), .asic_chip_rst(chip_rst), .asic_pcie_rst(pcie_rst),
        .optics_rst(o_rst), .optics_lpmode(o_lp));

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int        m_pg, m_rec, m_wait;
    bit        m_rel, m_pwr;
    logic [NP-1:0] m_orst, m_olp;
    logic      ph0, ph1;

    task model_clear();
        m_pg = 0; m_rec = 0; m_wait = 0; m_rel = 0; m_pwr = 0;
        m_orst = '1; m_olp = '1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_clear();
            ph0 = 1'b0; ph1 = 1'b0;
        end else begin
            if (cmd_v && cmd == 2'd3) begin
                model_clear();
            end else begin
                bit started;
                started = 1'b0;
                if (cmd_v && cmd == 2'd0 && !m_pwr) begin
                    m_pwr = 1; m_wait = HD; started = 1;
                end else if (cmd_v && cmd == 2'd1) begin
                    m_pwr = 0; m_wait = 0; started = 1;
                end else if (cmd_v && cmd == 2'd2 && m_pwr) begin
                    m_wait = HD; started = 1;
                end
                if (!started && m_wait > 0) m_wait--;
                if (!m_rel) begin
                    if (pg) begin
                        m_pg++;
                        if (m_pg == CHIP_DLY) m_rel = 1;
                    end else m_pg = 0;
                end
                if (wr && addr == 2'd1 && wdata[0]) m_rec = RECOV;
                else if (m_rec > 0) m_rec--;
                if (wr && addr == 2'd2) m_orst = wdata[NP-1:0];
                if (wr && addr == 2'd3) m_olp  = wdata[NP-1:0];
            end
            ph1 = ph0;
            ph0 = plat_n;
        end
    end

    function automatic logic [DW-1:0] exp_rdata(logic [1:0] a);
        case (a)
            2'd0: return 16'h0103;
            2'd2: return DW'(m_orst);
            2'd3: return DW'(m_olp);
            default: return '0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit m_chip;
            m_chip = !m_rel || (m_rec > 0);
            check("R3 host", {host_pwr_en, host_rst}, {m_pwr, (!m_pwr || m_wait > 0)});
            check("R2 chip", chip_rst, m_chip);
            check("R4 pcie", pcie_rst, (m_chip || !ph1));
            check("R8 optics rst", o_rst, m_orst);
            check("R8 optics lp", o_lp, m_olp);
            check("R9 rdata", rdata, exp_rdata(addr));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic send_cmd(logic [1:0] c);
        cmd = c; cmd_v = 1'b1;
        cyc();
        cmd_v = 1'b0;
    endtask

    task automatic reg_write(logic [1:0] a, logic [DW-1:0] d);
        cyc();
        addr = a; wdata = d; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) cyc();
        rst = 1'b0;
        @(negedge clk);
        // R1 power-up state
        check("R1 pwr_en", host_pwr_en, 1'b0);
        check("R1 host_rst", host_rst, 1'b1);
        check("R1 chip", chip_rst, 1'b1);
        check("R1 pcie", pcie_rst, 1'b1);
        check("R1 optics", o_rst, 8'hFF);
        check("R1 lp", o_lp, 8'hFF);

        // R2 supply glitch restarts the count
        cyc(); pg = 1'b1;
        repeat (500) cyc();
        pg = 1'b0;
        repeat (3) cyc();
        pg = 1'b1;
        repeat (CHIP_DLY - 1) cyc();
        @(negedge clk); check("R2 before release", chip_rst, 1'b1);
        cyc();
        @(negedge clk); check("R2 release", chip_rst, 1'b0);
        pg = 1'b0;
        repeat (5) cyc();
        @(negedge clk); check("R2 latched", chip_rst, 1'b0);

        // R3 host on
        send_cmd(2'd0);
        @(negedge clk);
        check("R3 pwr_en on", host_pwr_en, 1'b1);
        check("R3 held", host_rst, 1'b1);
        check("R6 optics after on", o_rst, 8'hFF);
        repeat (HD - 1) cyc();
        @(negedge clk); check("R3 still held", host_rst, 1'b1);
        cyc();
        @(negedge clk); check("R3 released", host_rst, 1'b0);

        // R4 platform reset reaches PCIe reset only
        plat_n = 1'b0;
        cyc();
        @(negedge clk); check("R4 sync stage1", pcie_rst, 1'b0);
        cyc();
        @(negedge clk);
        check("R4 pcie asserted", pcie_rst, 1'b1);
        check("R4 chip untouched", chip_rst, 1'b0);
        repeat (10) cyc();
        plat_n = 1'b1;
        cyc(); cyc();
        @(negedge clk);
        check("R4 pcie released", pcie_rst, 1'b0);
        check("R4 chip still free", chip_rst, 1'b0);

        // R10 host reset while powered
        send_cmd(2'd2);
        @(negedge clk);
        check("R10 host_rst", host_rst, 1'b1);
        check("R10 pwr kept", host_pwr_en, 1'b1);
        check("R6 optics after cycle", o_rst, 8'hFF);
        repeat (HD) cyc();
        @(negedge clk); check("R10 release", host_rst, 1'b0);

        // R3 host off, R10 reset ignored while off
        send_cmd(2'd1);
        @(negedge clk);
        check("R3 off pwr", host_pwr_en, 1'b0);
        check("R3 off rst", host_rst, 1'b1);
        send_cmd(2'd2);
        @(negedge clk);
        check("R10 ignored pwr", host_pwr_en, 1'b0);
        check("R6 lp after off", o_lp, 8'hFF);

        // R8 per-port optics registers, 1-based ports
        reg_write(2'd2, 16'h00A5);
        @(negedge clk);
        check("R8 rst vec", o_rst, 8'hA5);
        check("R8 port1", o_rst[1], 1'b1);
        check("R8 port2", o_rst[2], 1'b0);
        check("R8 readback rst", rdata, 16'h00A5);
        reg_write(2'd3, 16'h003C);
        @(negedge clk);
        check("R8 lp vec", o_lp, 8'h3C);
        check("R8 port3 lp", o_lp[3], 1'b1);
        check("R8 readback lp", rdata, 16'h003C);

        // R9 version
        cyc(); addr = 2'd0;
        @(negedge clk); check("R9 version", rdata, 16'h0103);
        reg_write(2'd0, 16'hFFFF);
        @(negedge clk);
        check("R9 write ignored", rdata, 16'h0103);
        check("R9 optics kept", o_rst, 8'hA5);

        // R5 recovery reset
        reg_write(2'd1, 16'h0000);
        @(negedge clk); check("R5 bit0 clear ignored", chip_rst, 1'b0);
        reg_write(2'd1, 16'h0001);
        @(negedge clk);
        check("R5 chip asserted", chip_rst, 1'b1);
        check("R5 pcie asserted", pcie_rst, 1'b1);
        repeat (RECOV - 1) cyc();
        @(negedge clk); check("R5 last cycle", chip_rst, 1'b1);
        cyc();
        @(negedge clk);
        check("R5 chip auto release", chip_rst, 1'b0);
        check("R5 pcie auto release", pcie_rst, 1'b0);
        check("R6 optics after recovery", o_rst, 8'hA5);

        // R7 chassis reset
        send_cmd(2'd0);
        repeat (3) cyc();
        send_cmd(2'd3);
        @(negedge clk);
        check("R7 pwr", host_pwr_en, 1'b0);
        check("R7 host_rst", host_rst, 1'b1);
        check("R7 chip", chip_rst, 1'b1);
        check("R7 pcie", pcie_rst, 1'b1);
        check("R7 optics", o_rst, 8'hFF);
        check("R7 lp", o_lp, 8'hFF);
        cyc(); addr = 2'd2;
        @(negedge clk); check("R7 readback", rdata, 16'h00FF);

        // R2 release again after chassis reset
        cyc(); pg = 1'b1;
        repeat (CHIP_DLY + 20) cyc();
        @(negedge clk); check("R2 re-release", chip_rst, 1'b0);

        finish_run();
    end
endmodule